// File: doc/BRIEF.md
# Mixed-Format Fixed-Point Add/Multiply Unit

This unit does two's-complement fixed-point arithmetic on two WIDTH-bit operands. Each operand has its own fractional-bit count, supplied at run time, so one operand can be an integer while the other is a pure fraction or anything in between. The unit lines up the binary points itself and reports the format of every result. No software-visible format state is involved.

An addition forms the exact sum at the larger of the two fractional counts. It then rescales that sum to a requested output format and returns WIDTH bits, with a flag when the value does not fit. A multiplication returns the full double-width product, whose fractional count is the sum of the two operand counts. A request whose format counts fall outside the legal range is refused with an error flag. The unit is a single registered stage.

Top module: `fxpArithUnit`

## Requirements
- R1: A synchronous active-high `rst` clears `outValid`, `result`, `resultQ`, `overflow` and `error`. `outValid` is low in every cycle that does not follow an accepted `inValid`. When no request arrives, the other outputs keep their previous values.
- R2: Each request presented with `inValid` high produces its outputs, with `outValid` high, exactly one clock later.
- R3: With `opSel`=0 (add), the operand with fewer fractional bits is shifted left to the larger count and the exact sum is formed. The sum is then rescaled to `qOut` fractional bits. Rescaling shifts left when `qOut` is larger and shifts arithmetically right when `qOut` is smaller, which truncates toward minus infinity. The low WIDTH bits of the rescaled sum, sign-extended to 2*WIDTH bits, appear on `result`.
- R4: `resultQ` equals `qOut` for an addition and `qA`+`qB` for a multiplication.
- R5: For an addition, `overflow` is 1 exactly when the rescaled sum cannot be held as a WIDTH-bit two's-complement value. A sum that only temporarily exceeds WIDTH bits before a right shift brings it back into range is not an overflow.
- R6: With `opSel`=1 (multiply), `result` is the exact 2*WIDTH-bit signed product of the operands, and `overflow` is 0. `qOut` has no effect on a multiplication.
- R7: The same path handles integer operands (q=0), fractional operands (q=WIDTH-1) and mixtures of the two.
- R8: A request is refused when `qA` or `qB` exceeds WIDTH-1, or, for an addition only, when `qOut` exceeds WIDTH-1. A refused request gives `outValid`=1 and `error`=1, with `result`=0, `resultQ`=0 and `overflow`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| inValid | input | 1 | Request strobe |
| opSel | input | 1 | 0 = add, 1 = multiply |
| opA | input | WIDTH | First operand, two's complement |
| opB | input | WIDTH | Second operand, two's complement |
| qA | input | QW | Fractional bits of opA |
| qB | input | QW | Fractional bits of opB |
| qOut | input | QW | Requested fractional bits of an addition result |
| outValid | output | 1 | Result strobe, one cycle after inValid |
| result | output | 2*WIDTH | Sign-extended sum or full product |
| resultQ | output | QW | Fractional bits of result |
| overflow | output | 1 | Addition result did not fit in WIDTH bits |
| error | output | 1 | Request refused because a format count is out of range |

## Verification
The assertions check several properties on every cycle:
- The one-cycle valid latency.
- That a refused request yields a zeroed result.
- That a product never raises overflow.
- That an addition result is always a clean sign extension of WIDTH bits.
- That a multiplication's result format is the sum of the input formats.

Only the bench's directed scenarios can show the numeric values. These cover alignment of mismatched binary points, truncation of negative sums toward minus infinity, left rescaling that overflows, temporary overflow that rescaling absorbs, and exact products at both the integer and fractional extremes.

// File: rtl/fxpArithPkg.sv
package fxpArithPkg;

  typedef enum logic {
    FX_ADD = 1'b0,
    FX_MUL = 1'b1
  } fxOp_t;

  typedef struct packed {
    logic load;    // a request is taken this cycle
    logic doMul;   // multiply rather than add
    logic reject;  // format counts out of range
  } fxStrobe_t;

endpackage

// File: rtl/fxpArithCtrl.sv
module fxpArithCtrl
  import fxpArithPkg::*;
#(
  parameter int WIDTH = 8,
  parameter int QW    = $clog2(WIDTH) + 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          inValid,
  input  logic          opSel,
  input  logic [QW-1:0] qA,
  input  logic [QW-1:0] qB,
  input  logic [QW-1:0] qOut,
  output fxStrobe_t     strobe
);

  localparam logic [QW-1:0] MAXQ = QW'(WIDTH - 1);

  fxOp_t op;
  logic  qInRange;

  always_comb begin
    op       = fxOp_t'(opSel);
    qInRange = (qA <= MAXQ) && (qB <= MAXQ) &&
               ((op == FX_MUL) || (qOut <= MAXQ));
    strobe.load   = inValid;
    strobe.doMul  = inValid && (op == FX_MUL);
    strobe.reject = inValid && !qInRange;
  end

  // R8: a refusal never occurs without a request
  a_r8_reject_needs_request: assert property (@(posedge clk) disable iff (rst)
    strobe.reject |-> strobe.load);

  // R8: an operand count above the limit is always refused
  a_r8_operand_q_refused: assert property (@(posedge clk) disable iff (rst)
    (inValid && ((qA > MAXQ) || (qB > MAXQ))) |-> strobe.reject);

endmodule

// File: rtl/fxpArithDatapath.sv
module fxpArithDatapath
  import fxpArithPkg::*;
#(
  parameter int WIDTH = 8,
  parameter int QW    = $clog2(WIDTH) + 1
) (
  input  logic                 clk,
  input  logic                 rst,
  input  fxStrobe_t            strobe,
  input  logic [WIDTH-1:0]     opA,
  input  logic [WIDTH-1:0]     opB,
  input  logic [QW-1:0]        qA,
  input  logic [QW-1:0]        qB,
  input  logic [QW-1:0]        qOut,
  output logic                 outValid,
  output logic [2*WIDTH-1:0]   result,
  output logic [QW-1:0]        resultQ,
  output logic                 overflow,
  output logic                 error
);

  localparam int PW   = 2 * WIDTH;      // product width
  localparam int EXTW = 3 * WIDTH + 1;  // exact room for align + left rescale
  localparam int HIW  = EXTW - WIDTH + 1;

  logic [QW-1:0]          qMax, shiftA, shiftB;
  logic signed [EXTW-1:0] extA, extB, alignA, alignB, sumW, scaled;
  logic [HIW-1:0]         hiBits;
  logic                   addOvf;
  logic [PW-1:0]          addRes;
  logic signed [PW-1:0]   mulA, mulB, product;

  // addition: align, sum exactly, rescale to requested format
  always_comb begin
    qMax   = (qA > qB) ? qA : qB;
    shiftA = qMax - qA;
    shiftB = qMax - qB;
    extA   = {{(EXTW-WIDTH){opA[WIDTH-1]}}, opA};
    extB   = {{(EXTW-WIDTH){opB[WIDTH-1]}}, opB};
    alignA = extA <<< shiftA;
    alignB = extB <<< shiftB;
    sumW   = alignA + alignB;
    if (qOut >= qMax) scaled = sumW <<< (qOut - qMax);
    else              scaled = sumW >>> (qMax - qOut);
    hiBits = scaled[EXTW-1:WIDTH-1];
    addOvf = !((&hiBits) || !(|hiBits));
    addRes = {{WIDTH{scaled[WIDTH-1]}}, scaled[WIDTH-1:0]};
  end

  // multiplication: full-width signed product
  always_comb begin
    mulA    = {{WIDTH{opA[WIDTH-1]}}, opA};
    mulB    = {{WIDTH{opB[WIDTH-1]}}, opB};
    product = mulA * mulB;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      outValid <= 1'b0;
      result   <= '0;
      resultQ  <= '0;
      overflow <= 1'b0;
      error    <= 1'b0;
    end else if (strobe.load) begin
      outValid <= 1'b1;
      if (strobe.reject) begin
        result   <= '0;
        resultQ  <= '0;
        overflow <= 1'b0;
        error    <= 1'b1;
      end else if (strobe.doMul) begin
        result   <= product;
        resultQ  <= qA + qB;
        overflow <= 1'b0;
        error    <= 1'b0;
      end else begin
        result   <= addRes;
        resultQ  <= qOut;
        overflow <= addOvf;
        error    <= 1'b0;
      end
    end else begin
      outValid <= 1'b0;
    end
  end

  // R2: one-cycle latency
  a_r2_valid_latency: assert property (@(posedge clk) disable iff (rst)
    strobe.load |=> outValid);

  // R1: no result strobe without a request in the previous cycle
  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (rst)
    !strobe.load |=> !outValid);

  // R8: a refused request yields a zeroed, non-overflowing result
  a_r8_reject_clean: assert property (@(posedge clk) disable iff (rst)
    (strobe.load && strobe.reject) |=> (error && result == '0 && !overflow && resultQ == '0));

  // R6: a product never raises overflow
  a_r6_mul_no_overflow: assert property (@(posedge clk) disable iff (rst)
    (strobe.load && strobe.doMul && !strobe.reject) |=> (!overflow && !error));

  // R4: product format is the sum of operand formats
  a_r4_mul_format: assert property (@(posedge clk) disable iff (rst)
    (strobe.load && strobe.doMul && !strobe.reject) |=> (resultQ == $past(qA) + $past(qB)));

  // R3: an addition result is a clean sign extension of WIDTH bits
  a_r3_add_sign_extended: assert property (@(posedge clk) disable iff (rst)
    (strobe.load && !strobe.doMul && !strobe.reject) |=>
      ((&result[PW-1:WIDTH-1]) || !(|result[PW-1:WIDTH-1])));

endmodule

// File: rtl/fxpArithUnit.sv
module fxpArithUnit
  import fxpArithPkg::*;
#(
  parameter int WIDTH = 8,
  parameter int QW    = $clog2(WIDTH) + 1
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 inValid,
  input  logic                 opSel,
  input  logic [WIDTH-1:0]     opA,
  input  logic [WIDTH-1:0]     opB,
  input  logic [QW-1:0]        qA,
  input  logic [QW-1:0]        qB,
  input  logic [QW-1:0]        qOut,
  output logic                 outValid,
  output logic [2*WIDTH-1:0]   result,
  output logic [QW-1:0]        resultQ,
  output logic                 overflow,
  output logic                 error
);

  fxStrobe_t strobe;

  fxpArithCtrl #(.WIDTH(WIDTH), .QW(QW)) u_ctrl (
    .clk     (clk),
    .rst     (rst),
    .inValid (inValid),
    .opSel   (opSel),
    .qA      (qA),
    .qB      (qB),
    .qOut    (qOut),
    .strobe  (strobe)
  );

  fxpArithDatapath #(.WIDTH(WIDTH), .QW(QW)) u_datapath (
    .clk      (clk),
    .rst      (rst),
    .strobe   (strobe),
    .opA      (opA),
    .opB      (opB),
    .qA       (qA),
    .qB       (qB),
    .qOut     (qOut),
    .outValid (outValid),
    .result   (result),
    .resultQ  (resultQ),
    .overflow (overflow),
    .error    (error)
  );

endmodule

// File: tb/fxpArithUnit_bench.sv
`timescale 1ns/1ps
module fxpArithUnit_bench;

  localparam int WIDTH = 8;
  localparam int QW    = $clog2(WIDTH) + 1;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              inValid = 1'b0;
  logic              opSel = 1'b0;
  logic [WIDTH-1:0]  opA = '0, opB = '0;
  logic [QW-1:0]     qA = '0, qB = '0, qOut = '0;
  logic              outValid;
  logic [2*WIDTH-1:0] result;
  logic [QW-1:0]     resultQ;
  logic              overflow, error;

  int nChecks = 0;
  int nFails  = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;   // 250 MHz

  fxpArithUnit #(.WIDTH(WIDTH), .QW(QW)) u_fxpArithUnit (
    .clk(clk), .rst(rst), .inValid(inValid), .opSel(opSel),
    .opA(opA), .opB(opB), .qA(qA), .qB(qB), .qOut(qOut),
    .outValid(outValid), .result(result), .resultQ(resultQ),
    .overflow(overflow), .error(error)
  );

  task automatic check(string req, string what, longint act, longint exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  // apply one request, then check the registered outputs one cycle later
  task automatic runOp(string req, logic op, logic [7:0] a, logic [7:0] b,
                       logic [3:0] qa, logic [3:0] qb, logic [3:0] qo,
                       logic [15:0] expRes, logic [3:0] expQ,
                       logic expOvf, logic expErr);
    @(negedge clk);
    inValid = 1'b1; opSel = op; opA = a; opB = b; qA = qa; qB = qb; qOut = qo;
    @(negedge clk);
    inValid = 1'b0;
    check(req, "outValid", outValid, 1);
    check(req, "result",   result,   expRes);
    check(req, "resultQ",  resultQ,  expQ);
    check(req, "overflow", overflow, expOvf);
    check(req, "error",    error,    expErr);
  endtask

  task automatic testReset();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    check("R1", "outValid after reset", outValid, 0);
    check("R1", "result after reset", result, 0);
    check("R1", "error after reset", error, 0);
    rst = 1'b0;
  endtask

  task automatic testMixedAdd();
    // -19/8 (q3) + 97/16 (q4) = 59/16 at q4
    runOp("R3", 1'b0, 8'hED, 8'h61, 4'd3, 4'd4, 4'd4, 16'h003B, 4'd4, 0, 0);
    // R7 mixture: 0.5 (q7) + 1 (q0) at q7 -> 192/128 does not fit
    runOp("R7", 1'b0, 8'h40, 8'h01, 4'd7, 4'd0, 4'd7, 16'hFFC0, 4'd7, 1, 0);
    // same sum at q4 -> 24, the wide intermediate is absorbed (R5)
    runOp("R5", 1'b0, 8'h40, 8'h01, 4'd7, 4'd0, 4'd4, 16'h0018, 4'd4, 0, 0);
  endtask

  task automatic testRescale();
    runOp("R3", 1'b0, 8'h11, 8'h01, 4'd4, 4'd4, 4'd1, 16'h0002, 4'd1, 0, 0);
    // negative truncation toward minus infinity: -17/16 -> -3/2
    runOp("R3", 1'b0, 8'hEF, 8'h00, 4'd4, 4'd4, 4'd1, 16'hFFFD, 4'd1, 0, 0);
    runOp("R3", 1'b0, 8'h03, 8'h04, 4'd0, 4'd0, 4'd4, 16'h0070, 4'd4, 0, 0);
    runOp("R5", 1'b0, 8'h03, 8'h04, 4'd0, 4'd0, 4'd5, 16'hFFE0, 4'd5, 1, 0);
  endtask

  task automatic testAddOverflow();
    runOp("R5", 1'b0, 8'h64, 8'h64, 4'd0, 4'd0, 4'd0, 16'hFFC8, 4'd0, 1, 0);
    // R7 fractional extremes
    runOp("R7", 1'b0, 8'h40, 8'h40, 4'd7, 4'd7, 4'd7, 16'hFF80, 4'd7, 1, 0);
    runOp("R7", 1'b0, 8'hC0, 8'hC0, 4'd7, 4'd7, 4'd7, 16'hFF80, 4'd7, 0, 0);
  endtask

  task automatic testMultiply();
    runOp("R6", 1'b1, 8'hED, 8'h61, 4'd3, 4'd4, 4'd0, 16'hF8CD, 4'd7, 0, 0);
    runOp("R7", 1'b1, 8'h80, 8'h80, 4'd7, 4'd7, 4'd0, 16'h4000, 4'd14, 0, 0);
    runOp("R6", 1'b1, 8'h7F, 8'h80, 4'd0, 4'd0, 4'd0, 16'hC080, 4'd0, 0, 0);
    // R4/R6: an out-of-range qOut has no effect on a multiply
    runOp("R4", 1'b1, 8'h04, 8'h02, 4'd2, 4'd1, 4'd15, 16'h0008, 4'd3, 0, 0);
  endtask

  task automatic testReject();
    runOp("R8", 1'b0, 8'h11, 8'h22, 4'd8, 4'd1, 4'd1, 16'h0000, 4'd0, 0, 1);
    runOp("R8", 1'b1, 8'h11, 8'h22, 4'd1, 4'd9, 4'd0, 16'h0000, 4'd0, 0, 1);
    runOp("R8", 1'b0, 8'h11, 8'h22, 4'd1, 4'd1, 4'd8, 16'h0000, 4'd0, 0, 1);
  endtask

  task automatic testIdleAndLatency();
    runOp("R2", 1'b0, 8'h05, 8'h06, 4'd0, 4'd0, 4'd0, 16'h000B, 4'd0, 0, 0);
    @(negedge clk);
    check("R1", "outValid idle", outValid, 0);
    check("R1", "result held idle", result, 16'h000B);
    // reset mid-stream clears outputs
    @(negedge clk);
    inValid = 1'b1; opSel = 1'b0; opA = 8'h01; opB = 8'h01; qA = 0; qB = 0; qOut = 0;
    rst = 1'b1;
    @(negedge clk);
    inValid = 1'b0; rst = 1'b0;
    check("R1", "outValid under reset", outValid, 0);
    check("R1", "result under reset", result, 0);
  endtask

  initial begin
    testReset();
    testMixedAdd();
    testRescale();
    testAddOverflow();
    testMultiply();
    testReject();
    testIdleAndLatency();
    if (!finished) begin
      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    #(4 * 100000);
    if (!finished) begin
      finished = 1'b1;
      nChecks++;
      nFails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end

endmodule